// File: doc/BRIEF.md
# Memory Slot Hotplug Register Block

This block tells platform firmware which memory slots have gained or lost a module. Inside the chip, requests to add or remove a slot arrive on two request channels, each with a slot index. The block keeps one presence bit per slot. On every add or remove it also latches a shared memory-hotplug event flag. When that flag and its enable are both set, the block raises a level-sensitive system control interrupt.

The host reaches the block through a byte-wide I/O window. Firmware reads the presence bitmap one byte at a time, at a fixed base address. It clears the event flag by writing a one to it, and sets up the enable byte. When the operating system has finished taking a module offline, it writes that module's slot number to a write-only eject byte. The block answers with a one-cycle removal-complete pulse that carries the slot number. The bitmap itself can never be written from the host side.

Top module: `memhp_regs`

## Requirements
- R1: After reset every presence bit is 0, the event status and enable bytes read 0x00, `sci` is low and `ej_vld` is low.
- R2: A cycle with `add_vld` high and slot index n sets presence bit n. Bit n is found in the byte at address 0xAF80 + n/8, at bit position n mod 8, and the read shows it from the next cycle.
- R3: A cycle with `rem_vld` high and slot index n clears presence bit n from the next cycle.
- R4: Every add or remove sets bit 3 (0x08) of the event status byte at 0xAF00 from the next cycle. No other status bit is ever set.
- R5: If an add and a remove name the same slot in the same cycle, the slot ends up cleared. If they name different slots, both take effect.
- R6: Writes to the bitmap range 0xAF80 to 0xAF9F change nothing.
- R7: A write to the status address clears each status bit where the written byte holds a 1, and leaves the other bits alone. An add or remove in the same cycle keeps bit 3 set.
- R8: The enable byte at 0xAF02 is plain read/write and reads back the last value written.
- R9: `sci` is high exactly while (status AND enable) has bit 3 or bit 1 set. It follows a status or enable change on the next cycle.
- R10: A write of value v to the eject address 0xAFA0 gives `ej_vld` high for one cycle, in the next cycle, with `ej_slot` = v. The presence bitmap does not change, and reading the eject address returns 0x00.
- R11: `io_rdata` is 0x00 when `io_rd` is low, and 0x00 for a read of any unmapped address. For a mapped address it is valid in the same cycle as `io_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| add_vld | input | 1 | Slot add request, one cycle per request |
| add_slot | input | SLOTW (8) | Slot index of the add request |
| rem_vld | input | 1 | Slot remove request, one cycle per request |
| rem_slot | input | SLOTW (8) | Slot index of the remove request |
| io_addr | input | 16 | Host I/O byte address |
| io_rd | input | 1 | Host read strobe |
| io_wr | input | 1 | Host write strobe, one write per cycle |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data (combinational) |
| sci | output | 1 | Level system control interrupt |
| ej_vld | output | 1 | Removal-complete pulse |
| ej_slot | output | 8 | Slot number, valid while `ej_vld` is high |

## Verification
A wrong presence bit shows up in the very next cycle, at the bitmap byte that holds the slot. Reading back the byte next to it exposes any stray bit in a neighbouring slot. A status flag that is set or cleared wrongly moves `sci` one cycle after the event or the clearing write, so the interrupt pin shows the fault at once when the enable is set. A broken eject path shows as a missing or extra `ej_vld` pulse, or a wrong `ej_slot`, in the cycle after the write.

// File: rtl/memhp_pkg.sv
package memhp_pkg;

    localparam int HP_BYTE_W   = 8;
    localparam int HP_MEM_BIT  = 3;
    localparam int HP_PCI_BIT  = 1;

    // status bits that may ever be set by this block
    localparam logic [HP_BYTE_W-1:0] HP_STS_IMPL = 8'h08;
    // status bits that may raise the interrupt
    localparam logic [HP_BYTE_W-1:0] HP_SCI_MASK = 8'h0A;

    typedef struct packed {
        logic [HP_BYTE_W-1:0] sts;
        logic [HP_BYTE_W-1:0] en;
    } gpe_state_t;

    typedef struct packed {
        logic                 vld;
        logic [HP_BYTE_W-1:0] slot;
    } eject_state_t;

endpackage

// File: rtl/memhp_bitmap.sv
module memhp_bitmap #(
    parameter int NSLOTS = 256,
    localparam int SLOTW  = $clog2(NSLOTS),
    localparam int NBYTES = NSLOTS / 8,
    localparam int IDXW   = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_vld,
    input  logic [SLOTW-1:0]  add_slot,
    input  logic              rem_vld,
    input  logic [SLOTW-1:0]  rem_slot,
    input  logic [IDXW-1:0]   rd_idx,
    output logic [7:0]        rd_byte,
    output logic [NSLOTS-1:0] bits
);

    logic [NSLOTS-1:0] map_d, map_q;
    logic [7:0]        byte_view [NBYTES];

    always_comb begin
        map_d = map_q;
        if (add_vld) map_d[add_slot] = 1'b1;
        // remove is applied last so it wins on the same slot
        if (rem_vld) map_d[rem_slot] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_d;
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign byte_view[b] = map_q[b*8 +: 8];
    end

    assign rd_byte = byte_view[rd_idx];
    assign bits    = map_q;

endmodule

// File: rtl/memhp_gpe.sv
module memhp_gpe
    import memhp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt,
    input  logic                 sts_wr,
    input  logic                 en_wr,
    input  logic [HP_BYTE_W-1:0] wdata,
    output logic [HP_BYTE_W-1:0] sts,
    output logic [HP_BYTE_W-1:0] en,
    output logic                 sci
);

    gpe_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sts_wr) st_d.sts = st_q.sts & ~wdata;
        if (en_wr)  st_d.en  = wdata;
        if (evt)    st_d.sts[HP_MEM_BIT] = 1'b1;
        st_d.sts = st_d.sts & HP_STS_IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts = st_q.sts;
    assign en  = st_q.en;
    assign sci = |(st_q.sts & st_q.en & HP_SCI_MASK);

endmodule

// File: rtl/memhp_ejector.sv
module memhp_ejector
    import memhp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic [HP_BYTE_W-1:0] wdata,
    output logic                 ej_vld,
    output logic [HP_BYTE_W-1:0] ej_slot
);

    eject_state_t ej_d, ej_q;

    always_comb begin
        ej_d.vld  = hit;
        ej_d.slot = hit ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ej_q <= '0;
        else        ej_q <= ej_d;
    end

    assign ej_vld  = ej_q.vld;
    assign ej_slot = ej_q.slot;

endmodule

// File: rtl/memhp_regs.sv
module memhp_regs
    import memhp_pkg::*;
#(
    parameter int              NSLOTS   = 256,
    parameter int              ADDR_W   = 16,
    parameter logic [15:0]     MAP_BASE = 16'hAF80,
    parameter logic [15:0]     EJ_ADDR  = 16'hAFA0,
    parameter logic [15:0]     STS_ADDR = 16'hAF00,
    parameter logic [15:0]     EN_ADDR  = 16'hAF02,
    localparam int SLOTW  = $clog2(NSLOTS),
    localparam int NBYTES = NSLOTS / 8,
    localparam int IDXW   = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_vld,
    input  logic [SLOTW-1:0]  add_slot,
    input  logic              rem_vld,
    input  logic [SLOTW-1:0]  rem_slot,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              sci,
    output logic              ej_vld,
    output logic [7:0]        ej_slot
);

    logic [ADDR_W-1:0] map_off;
    logic              map_hit, sts_hit, en_hit, ej_hit;
    logic [7:0]        map_byte, evt_sts, evt_en;
    logic [NSLOTS-1:0] slot_bits;

    assign map_off = io_addr - ADDR_W'(MAP_BASE);
    assign map_hit = map_off < ADDR_W'(NBYTES);
    assign sts_hit = io_addr == ADDR_W'(STS_ADDR);
    assign en_hit  = io_addr == ADDR_W'(EN_ADDR);
    assign ej_hit  = io_addr == ADDR_W'(EJ_ADDR);

    memhp_bitmap #(.NSLOTS(NSLOTS)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_vld (add_vld),
        .add_slot(add_slot),
        .rem_vld (rem_vld),
        .rem_slot(rem_slot),
        .rd_idx  (map_off[IDXW-1:0]),
        .rd_byte (map_byte),
        .bits    (slot_bits)
    );

    memhp_gpe u_gpe (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (add_vld | rem_vld),
        .sts_wr(io_wr & sts_hit),
        .en_wr (io_wr & en_hit),
        .wdata (io_wdata),
        .sts   (evt_sts),
        .en    (evt_en),
        .sci   (sci)
    );

    memhp_ejector u_ej (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (io_wr & ej_hit),
        .wdata  (io_wdata),
        .ej_vld (ej_vld),
        .ej_slot(ej_slot)
    );

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (map_hit)      io_rdata = map_byte;
            else if (sts_hit) io_rdata = evt_sts;
            else if (en_hit)  io_rdata = evt_en;
        end
    end

endmodule

// File: rtl/memhp_regs_chk.sv
module memhp_regs_chk #(
    parameter int          NSLOTS   = 256,
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] MAP_BASE = 16'hAF80,
    parameter logic [15:0] EJ_ADDR  = 16'hAFA0,
    parameter logic [15:0] EN_ADDR  = 16'hAF02,
    localparam int SLOTW  = $clog2(NSLOTS),
    localparam int NBYTES = NSLOTS / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              add_vld,
    input logic [SLOTW-1:0]  add_slot,
    input logic              rem_vld,
    input logic [SLOTW-1:0]  rem_slot,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              sci,
    input logic              ej_vld,
    input logic [7:0]        ej_slot,
    input logic [7:0]        evt_sts,
    input logic [7:0]        evt_en,
    input logic [NSLOTS-1:0] slot_bits
);

    logic map_wr;
    assign map_wr = io_wr && (io_addr >= ADDR_W'(MAP_BASE))
                    && (io_addr < ADDR_W'(MAP_BASE) + ADDR_W'(NBYTES));

    // R2
    add_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_vld && !(rem_vld && rem_slot == add_slot)) |=> slot_bits[$past(add_slot)]);

    // R3
    rem_clears_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rem_vld |=> !slot_bits[$past(rem_slot)]);

    // R4
    evt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_vld || rem_vld) |=> evt_sts[3]);

    // R6
    map_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map_wr && !add_vld && !rem_vld) |=> $stable(slot_bits));

    // R9
    sci_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((add_vld || rem_vld) && evt_en[3] && !(io_wr && io_addr == ADDR_W'(EN_ADDR))) |=> sci);

    // R10
    eject_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ej_vld |-> ($past(io_wr && io_addr == ADDR_W'(EJ_ADDR)) && ej_slot == $past(io_wdata)));

    // R11
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> io_rdata == 8'h00);

endmodule

bind memhp_regs memhp_regs_chk #(
    .NSLOTS(NSLOTS), .ADDR_W(ADDR_W), .MAP_BASE(MAP_BASE),
    .EJ_ADDR(EJ_ADDR), .EN_ADDR(EN_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .add_vld(add_vld), .add_slot(add_slot),
    .rem_vld(rem_vld), .rem_slot(rem_slot),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .sci(sci), .ej_vld(ej_vld), .ej_slot(ej_slot),
    .evt_sts(evt_sts), .evt_en(evt_en), .slot_bits(slot_bits)
);

// File: tb/memhp_regs_bench.sv
module memhp_regs_bench;

    localparam logic [15:0] MAPB = 16'hAF80;
    localparam logic [15:0] EJA  = 16'hAFA0;
    localparam logic [15:0] STSA = 16'hAF00;
    localparam logic [15:0] ENA  = 16'hAF02;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       add_vld = 1'b0, rem_vld = 1'b0;
    logic [7:0] add_slot = '0, rem_slot = '0;
    logic [15:0] io_addr = '0;
    logic       io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata, ej_slot;
    logic       sci, ej_vld;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    memhp_regs u_memhp_regs (
        .clk(clk), .rst_n(rst_n),
        .add_vld(add_vld), .add_slot(add_slot),
        .rem_vld(rem_vld), .rem_slot(rem_slot),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .sci(sci), .ej_vld(ej_vld), .ej_slot(ej_slot)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #2 v = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic req(input logic a, input logic [7:0] as, input logic r, input logic [7:0] rs);
        @(negedge clk);
        add_vld = a; add_slot = as; rem_vld = r; rem_slot = rs;
        @(negedge clk);
        add_vld = 1'b0; rem_vld = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(MAPB, v);        check("R1 byte0", v, 8'h00);
        rd(MAPB + 31, v);   check("R1 byte31", v, 8'h00);
        rd(STSA, v);        check("R1 sts", v, 8'h00);
        rd(ENA, v);         check("R1 en", v, 8'h00);
        check("R1 sci", {7'd0, sci}, 8'h00);
        check("R1 ej_vld", {7'd0, ej_vld}, 8'h00);
    endtask

    task automatic t_add_remove();
        logic [7:0] v;
        req(1, 8'd0, 0, 8'd0);
        req(1, 8'd13, 0, 8'd0);
        req(1, 8'd255, 0, 8'd0);
        rd(MAPB, v);        check("R2 slot0", v, 8'h01);
        rd(MAPB + 1, v);    check("R2 slot13", v, 8'h20);
        rd(MAPB + 31, v);   check("R2 slot255", v, 8'h80);
        rd(MAPB + 2, v);    check("R2 neighbour", v, 8'h00);
        rd(STSA, v);        check("R4 add flag", v, 8'h08);
        wr(STSA, 8'hFF);
        req(0, 8'd0, 1, 8'd13);
        rd(MAPB + 1, v);    check("R3 slot13", v, 8'h00);
        rd(STSA, v);        check("R4 remove flag", v, 8'h08);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        req(1, 8'd40, 0, 8'd0);
        req(1, 8'd40, 1, 8'd40);
        rd(MAPB + 5, v);    check("R5 same slot", v, 8'h00);
        req(1, 8'd50, 1, 8'd0);
        rd(MAPB + 6, v);    check("R5 diff add", v, 8'h04);
        rd(MAPB, v);        check("R5 diff rem", v, 8'h00);
    endtask

    task automatic t_readonly();
        logic [7:0] v;
        wr(MAPB + 6, 8'hFF);
        wr(MAPB + 7, 8'hFF);
        rd(MAPB + 6, v);    check("R6 write ignored", v, 8'h04);
        rd(MAPB + 7, v);    check("R6 write ignored 2", v, 8'h00);
    endtask

    task automatic t_w1c();
        logic [7:0] v;
        rd(STSA, v);        check("R7 pre", v, 8'h08);
        wr(STSA, 8'h00);
        rd(STSA, v);        check("R7 zero keeps", v, 8'h08);
        wr(STSA, 8'h08);
        rd(STSA, v);        check("R7 one clears", v, 8'h00);
        @(negedge clk);
        io_addr = STSA; io_wdata = 8'h08; io_wr = 1'b1;
        add_vld = 1'b1; add_slot = 8'd100;
        @(negedge clk);
        io_wr = 1'b0; add_vld = 1'b0;
        rd(STSA, v);        check("R7 event wins", v, 8'h08);
    endtask

    task automatic t_enable_sci();
        logic [7:0] v;
        wr(ENA, 8'hA5);
        rd(ENA, v);         check("R8 readback", v, 8'hA5);
        wr(ENA, 8'h00);
        check("R9 sci masked", {7'd0, sci}, 8'h00);
        wr(ENA, 8'h02);
        check("R9 pci bit only", {7'd0, sci}, 8'h00);
        wr(ENA, 8'h08);
        check("R9 sci high", {7'd0, sci}, 8'h01);
        wr(STSA, 8'h08);
        check("R9 sci cleared", {7'd0, sci}, 8'h00);
        req(0, 8'd0, 1, 8'd7);
        check("R9 sci on event", {7'd0, sci}, 8'h01);
        wr(STSA, 8'h08);
    endtask

    task automatic t_eject();
        logic [7:0] v;
        @(negedge clk);
        io_addr = EJA; io_wdata = 8'h32; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        check("R10 pulse", {7'd0, ej_vld}, 8'h01);
        check("R10 slot", ej_slot, 8'h32);
        @(negedge clk);
        check("R10 one cycle", {7'd0, ej_vld}, 8'h00);
        rd(EJA, v);         check("R10 write-only", v, 8'h00);
        rd(MAPB + 6, v);    check("R10 bitmap kept", v, 8'h04);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        rd(16'h1234, v);    check("R11 far", v, 8'h00);
        rd(MAPB - 1, v);    check("R11 below map", v, 8'h00);
        rd(16'hAF01, v);    check("R11 gap", v, 8'h00);
        @(negedge clk);
        io_addr = MAPB + 6; io_rd = 1'b0;
        #2 check("R11 no strobe", io_rdata, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_add_remove();
        t_collide();
        t_readonly();
        t_w1c();
        t_enable_sci();
        t_eject();
        t_unmapped();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule